// File: doc/BRIEF.md
# Clock Generator Configuration Serial Slave

This block is the serial configuration port of a clock generator. It watches a two-wire open-drain bus (SCL, SDA) and answers only frames sent to the 7-bit device address 1101010. In a write frame the first data byte loads an internal register pointer. Each later byte is written to the register the pointer names, and the pointer then steps by one. A read frame returns bytes starting at the pointer, and the pointer also steps after each byte. The usual way to read is to set the pointer, issue a repeated START, and then send the read address. One address returns a fixed identification byte and cannot be written.

Register contents travel over a plain register port: an address, write data, a one-cycle write strobe, and read data that the register file returns in the same cycle. A built-in behavioural non-volatile store keeps one byte for each working register. A frame that holds only the device address (write) and a single command byte, closed by STOP, starts a save (working registers to store) or a restore (store to working registers). The transfer moves one register every few cycles. While it runs, the slave acknowledges nothing. The transfer is refused while the shutdown input is high. If shutdown rises during a transfer, the transfer stops and an integrity error flag is raised. A START or STOP that arrives part way through a byte drops the frame and changes nothing.

Top module: `clkgen_cfg_slave`

## Requirements
- R1: The address byte 0xD4 (device address 1101010, write) or 0xD5 (read) is acknowledged. Any other address byte is not acknowledged, and the rest of that frame is ignored with no register write.
- R2: In a write frame the first data byte loads the pointer and does not write a register. Each further byte causes exactly one reg_we_o pulse at the pointer address with that byte, and the pointer then advances by one.
- R3: A read frame sends the byte at the pointer MSB first and advances the pointer after each byte. A master ACK asks for the next byte. A master NACK ends the read.
- R4: A repeated START with no STOP before it begins a new address phase.
- R5: Pointer value 0xFF selects a read-only identification register that reads 0x10. A write to it produces no reg_we_o, but it still advances the pointer.
- R6: A frame of exactly the write address and one command byte, followed by STOP, starts a save (0xC0) or a restore (0xC1). nv_busy_o is high within a few cycles after the STOP. Frames with more bytes start nothing.
- R7: While nv_busy_o is high, the slave never pulls SDA low, so even its own address goes unacknowledged.
- R8: A save copies registers 0..NREG-1 into the store. A restore writes each stored byte back to its register through reg_we_o, using only addresses below NREG.
- R9: A command that completes while shutdown_i is high is refused, and nv_busy_o stays low.
- R10: Shutdown_i rising during a transfer ends it on the next cycle with crc_err_o set. crc_err_o changes only while a transfer is running, and it is cleared when a later transfer completes in full.
- R11: A STOP or START after two or more bits of a byte aborts the frame. That partial byte writes nothing, changes no pointer, and starts no command.
- R12: In reset, SDA is released, reg_we_o is low, nv_busy_o is low and crc_err_o is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_pull_o | output | 1 | 1 pulls SDA low, 0 releases it |
| shutdown_i | input | 1 | Shutdown request, blocks or aborts store transfers |
| reg_addr_o | output | 8 | Register port address |
| reg_wdata_o | output | 8 | Register port write data |
| reg_we_o | output | 1 | Register port write strobe |
| reg_rdata_i | input | 8 | Register port read data, combinational on address |
| nv_busy_o | output | 1 | Store transfer in progress |
| crc_err_o | output | 1 | Last transfer was interrupted |

## Verification
The two store-control paths that can meet in one cycle are command launch and the shutdown guard, and the abort path can also meet the final step of a transfer. The bench holds shutdown high across the closing STOP of a save frame, so the launch pulse and the refusal arrive together; busy must stay low. It also raises shutdown in the middle of a save, and then expects busy to fall with the error flag set. A later complete save must clear that flag. A queue of expected register writes is compared every clock, so a launch or abort that stray-writes or swallows a write is caught.

// File: rtl/cfgslv_pkg.sv
package cfgslv_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RX,
    PH_ACKOUT,
    PH_TX,
    PH_ACKIN
  } phase_e;

  localparam logic [6:0] DEV_ADDR    = 7'b1101010;
  localparam logic [7:0] ID_VALUE    = 8'h10;
  localparam logic [7:0] CMD_SAVE    = 8'hC0;
  localparam logic [7:0] CMD_RESTORE = 8'hC1;
endpackage

// File: rtl/cfgslv_linesync.sv
module cfgslv_linesync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s      = scl_pipe[STAGES-1];
  assign sda_o      = sda_pipe[STAGES-1];
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  assign start_o    = scl_s & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/cfgslv_proto.sv
module cfgslv_proto
  import cfgslv_pkg::*;
#(
  parameter logic [7:0] ID_ADDR = 8'hFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start,
  input  logic       stop,
  input  logic       busy,
  input  logic [7:0] reg_rdata,
  output logic       sda_pull,
  output logic [7:0] ptr_o,
  output logic       wr_pulse_o,
  output logic [7:0] wr_addr_o,
  output logic [7:0] wr_data_o,
  output logic       go_save_o,
  output logic       go_restore_o
);
  phase_e     phase, phase_n;
  logic       is_addr, is_addr_n, is_read, is_read_n, mack, mack_n;
  logic       drv, drv_n, wr_p_n, gs_n, gr_n;
  logic [3:0] cnt, cnt_n;
  logic [1:0] nbytes, nbytes_n;
  logic [7:0] shreg, shreg_n, ptr, ptr_n, wa_n, wd_n, rd_byte;

  assign rd_byte = (ptr == ID_ADDR) ? ID_VALUE : reg_rdata;

  always_comb begin
    phase_n   = phase;
    is_addr_n = is_addr;
    is_read_n = is_read;
    mack_n    = mack;
    drv_n     = drv;
    cnt_n     = cnt;
    nbytes_n  = nbytes;
    shreg_n   = shreg;
    ptr_n     = ptr;
    wa_n      = wr_addr_o;
    wd_n      = wr_data_o;
    wr_p_n    = 1'b0;
    gs_n      = 1'b0;
    gr_n      = 1'b0;
    if (start) begin
      phase_n   = PH_RX;
      is_addr_n = 1'b1;
      cnt_n     = 4'd0;
      nbytes_n  = 2'd0;
      drv_n     = 1'b0;
    end else if (stop) begin
      // a clean STOP follows exactly one SCL rise of the next byte
      if (phase == PH_RX && !is_addr && cnt <= 4'd1 && nbytes == 2'd1) begin
        gs_n = (ptr == CMD_SAVE);
        gr_n = (ptr == CMD_RESTORE);
      end
      phase_n = PH_IDLE;
      drv_n   = 1'b0;
    end else begin
      case (phase)
        PH_RX: begin
          if (scl_rise) begin
            shreg_n = {shreg[6:0], sda_s};
            cnt_n   = cnt + 4'd1;
          end else if (scl_fall && cnt == 4'd8) begin
            if (is_addr) begin
              if (shreg[7:1] == DEV_ADDR && !busy) begin
                drv_n     = 1'b1;
                is_read_n = shreg[0];
                phase_n   = PH_ACKOUT;
              end else begin
                phase_n = PH_IDLE;
              end
            end else begin
              drv_n   = 1'b1;
              phase_n = PH_ACKOUT;
              if (nbytes == 2'd0) begin
                ptr_n = shreg;
              end else begin
                wr_p_n = (ptr != ID_ADDR);
                wa_n   = ptr;
                wd_n   = shreg;
                ptr_n  = ptr + 8'd1;
              end
              if (nbytes != 2'd2) nbytes_n = nbytes + 2'd1;
            end
          end
        end
        PH_ACKOUT: begin
          if (scl_fall) begin
            if (is_addr && is_read) begin
              shreg_n = {rd_byte[6:0], 1'b0};
              drv_n   = ~rd_byte[7];
              cnt_n   = 4'd1;
              phase_n = PH_TX;
            end else begin
              drv_n   = 1'b0;
              cnt_n   = 4'd0;
              phase_n = PH_RX;
            end
            is_addr_n = 1'b0;
          end
        end
        PH_TX: begin
          if (scl_fall) begin
            if (cnt == 4'd8) begin
              drv_n   = 1'b0;
              mack_n  = 1'b0;
              ptr_n   = ptr + 8'd1;
              phase_n = PH_ACKIN;
            end else begin
              drv_n   = ~shreg[7];
              shreg_n = {shreg[6:0], 1'b0};
              cnt_n   = cnt + 4'd1;
            end
          end
        end
        PH_ACKIN: begin
          if (scl_rise) begin
            mack_n = ~sda_s;
          end else if (scl_fall) begin
            if (mack) begin
              shreg_n = {rd_byte[6:0], 1'b0};
              drv_n   = ~rd_byte[7];
              cnt_n   = 4'd1;
              phase_n = PH_TX;
            end else begin
              phase_n = PH_IDLE;
            end
          end
        end
        default: phase_n = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase        <= PH_IDLE;
      is_addr      <= 1'b0;
      is_read      <= 1'b0;
      mack         <= 1'b0;
      drv          <= 1'b0;
      cnt          <= 4'd0;
      nbytes       <= 2'd0;
      shreg        <= 8'd0;
      ptr          <= 8'd0;
      wr_addr_o    <= 8'd0;
      wr_data_o    <= 8'd0;
      wr_pulse_o   <= 1'b0;
      go_save_o    <= 1'b0;
      go_restore_o <= 1'b0;
    end else begin
      phase        <= phase_n;
      is_addr      <= is_addr_n;
      is_read      <= is_read_n;
      mack         <= mack_n;
      drv          <= drv_n;
      cnt          <= cnt_n;
      nbytes       <= nbytes_n;
      shreg        <= shreg_n;
      ptr          <= ptr_n;
      wr_addr_o    <= wa_n;
      wr_data_o    <= wd_n;
      wr_pulse_o   <= wr_p_n;
      go_save_o    <= gs_n;
      go_restore_o <= gr_n;
    end
  end

  assign sda_pull = drv;
  assign ptr_o    = ptr;
endmodule

// File: rtl/cfgslv_nvstore.sv
module cfgslv_nvstore #(
  parameter int NREG        = 16,
  parameter int STEP_CYCLES = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go_save,
  input  logic       go_restore,
  input  logic       shutdown,
  input  logic [7:0] rdata,
  output logic       busy_o,
  output logic       crc_err_o,
  output logic [7:0] addr_o,
  output logic [7:0] wdata_o,
  output logic       we_o
);
  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1;
  localparam int SW = $clog2(STEP_CYCLES);
  localparam logic [IW-1:0] LAST_IDX  = IW'(NREG - 1);
  localparam logic [SW-1:0] LAST_STEP = SW'(STEP_CYCLES - 1);

  logic [7:0]    mem [NREG];
  logic          busy, busy_n, dir, dir_n, crc, crc_n;
  logic [IW-1:0] idx, idx_n;
  logic [SW-1:0] step, step_n;
  logic          step_done, mem_we;

  assign step_done = busy && !shutdown && (step == LAST_STEP);
  assign mem_we    = step_done && !dir;

  always_comb begin
    busy_n = busy;
    dir_n  = dir;
    crc_n  = crc;
    idx_n  = idx;
    step_n = step;
    if (!busy) begin
      if ((go_save || go_restore) && !shutdown) begin
        busy_n = 1'b1;
        dir_n  = go_restore;
        idx_n  = '0;
        step_n = '0;
      end
    end else if (shutdown) begin
      busy_n = 1'b0;
      crc_n  = 1'b1;
    end else if (step == LAST_STEP) begin
      step_n = '0;
      if (idx == LAST_IDX) begin
        busy_n = 1'b0;
        crc_n  = 1'b0;
      end else begin
        idx_n = idx + IW'(1);
      end
    end else begin
      step_n = step + SW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      dir  <= 1'b0;
      crc  <= 1'b0;
      idx  <= '0;
      step <= '0;
    end else begin
      busy <= busy_n;
      dir  <= dir_n;
      crc  <= crc_n;
      idx  <= idx_n;
      step <= step_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem[i] <= 8'd0;
    end else if (mem_we) begin
      mem[idx] <= rdata;
    end
  end

  assign busy_o    = busy;
  assign crc_err_o = crc;
  assign addr_o    = 8'(idx);
  assign wdata_o   = mem[idx];
  assign we_o      = step_done && dir;
endmodule

// File: rtl/clkgen_cfg_slave.sv
module clkgen_cfg_slave #(
  parameter int         NREG        = 16,
  parameter int         STEP_CYCLES = 64,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] ID_ADDR     = 8'hFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_o,
  input  logic       shutdown_i,
  output logic [7:0] reg_addr_o,
  output logic [7:0] reg_wdata_o,
  output logic       reg_we_o,
  input  logic [7:0] reg_rdata_i,
  output logic       nv_busy_o,
  output logic       crc_err_o
);
  logic [1:0] rst_pipe;
  logic       rst_core_n;
  logic       sda_s, scl_rise, scl_fall, start, stop;
  logic [7:0] ptr, wr_addr, wr_data, eng_addr, eng_wdata;
  logic       wr_pulse, go_save, go_restore, eng_we, busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  cfgslv_linesync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_core_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start), .stop_o(stop)
  );

  cfgslv_proto #(.ID_ADDR(ID_ADDR)) u_proto (
    .clk(clk), .rst_n(rst_core_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start(start), .stop(stop), .busy(busy),
    .reg_rdata(reg_rdata_i), .sda_pull(sda_pull_o), .ptr_o(ptr),
    .wr_pulse_o(wr_pulse), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .go_save_o(go_save), .go_restore_o(go_restore)
  );

  cfgslv_nvstore #(.NREG(NREG), .STEP_CYCLES(STEP_CYCLES)) u_store (
    .clk(clk), .rst_n(rst_core_n), .go_save(go_save), .go_restore(go_restore),
    .shutdown(shutdown_i), .rdata(reg_rdata_i), .busy_o(busy),
    .crc_err_o(crc_err_o), .addr_o(eng_addr), .wdata_o(eng_wdata), .we_o(eng_we)
  );

  assign reg_addr_o  = busy ? eng_addr : (wr_pulse ? wr_addr : ptr);
  assign reg_wdata_o = busy ? eng_wdata : wr_data;
  assign reg_we_o    = eng_we | wr_pulse;
  assign nv_busy_o   = busy;
endmodule

// File: rtl/cfgslv_checker.sv
module cfgslv_checker #(
  parameter int         NREG    = 16,
  parameter logic [7:0] ID_ADDR = 8'hFF
) (
  input logic       clk,
  input logic       rst_n,
  input logic       sda_pull_o,
  input logic       shutdown_i,
  input logic [7:0] reg_addr_o,
  input logic       reg_we_o,
  input logic       nv_busy_o,
  input logic       crc_err_o
);
  assert_busy_nack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    nv_busy_o |-> !sda_pull_o);

  assert_id_readonly_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we_o |-> (reg_addr_o != ID_ADDR));

  assert_restore_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we_o && nv_busy_o) |-> (reg_addr_o < 8'(NREG)));

  assert_refuse_shutdown_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!nv_busy_o && shutdown_i) |=> !nv_busy_o);

  assert_abort_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (nv_busy_o && shutdown_i) |=> (!nv_busy_o && crc_err_o));

  assert_crc_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !nv_busy_o |=> $stable(crc_err_o));
endmodule

bind clkgen_cfg_slave cfgslv_checker #(.NREG(NREG), .ID_ADDR(ID_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_pull_o(sda_pull_o), .shutdown_i(shutdown_i),
  .reg_addr_o(reg_addr_o), .reg_we_o(reg_we_o), .nv_busy_o(nv_busy_o),
  .crc_err_o(crc_err_o)
);

// File: tb/tb_clkgen_cfg_slave.sv
module tb_clkgen_cfg_slave;
  localparam int NREG = 16;
  localparam int STEP = 64;
  localparam int H    = 10;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n, scl_m, sda_m, shutdown;
  logic       sda_pull, reg_we, nv_busy, crc_err, sda_bus;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic [7:0] rf [NREG];
  logic [7:0] saved [NREG];
  logic [15:0] exp_wr[$];
  int nchk = 0, nfail = 0;

  assign sda_bus   = sda_m & ~sda_pull;
  assign reg_rdata = (reg_addr < 8'(NREG)) ? rf[reg_addr[3:0]] : 8'h00;

  clkgen_cfg_slave #(.NREG(NREG), .STEP_CYCLES(STEP)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_pull_o(sda_pull), .shutdown_i(shutdown), .reg_addr_o(reg_addr),
    .reg_wdata_o(reg_wdata), .reg_we_o(reg_we), .reg_rdata_i(reg_rdata),
    .nv_busy_o(nv_busy), .crc_err_o(crc_err)
  );

  always @(posedge clk)
    if (reg_we && reg_addr < 8'(NREG)) rf[reg_addr[3:0]] <= reg_wdata;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-clock reference: every write must match the next expected one
  always @(negedge clk) begin
    if (rst_n && reg_we) begin
      check(reg_addr != 8'hFF, "R5 write hit id reg", reg_addr, 32'hFF);
      if (nv_busy) begin
        check(reg_addr < 8'(NREG) && reg_wdata == saved[reg_addr[3:0]], "R8 restore write",
              {reg_addr, reg_wdata}, {reg_addr, saved[reg_addr[3:0]]});
      end else if (exp_wr.size() == 0) begin
        check(1'b0, "R2 unexpected write", {reg_addr, reg_wdata}, 0);
      end else begin
        logic [15:0] e;
        e = exp_wr.pop_front();
        check({reg_addr, reg_wdata} == e, "R2 write addr/data", {reg_addr, reg_wdata}, e);
      end
    end
  end

  task automatic wait_c(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; wait_c(H); scl_m = 1'b1; wait_c(H);
    sda_m = 1'b0; wait_c(H); scl_m = 1'b0; wait_c(H);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; wait_c(H); scl_m = 1'b1; wait_c(H); sda_m = 1'b1; wait_c(H);
  endtask

  task automatic put_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; wait_c(H); scl_m = 1'b1; wait_c(H); scl_m = 1'b0; wait_c(2);
    end
  endtask

  task automatic put_byte(input logic [7:0] b, output bit ack);
    put_bits(b, 8);
    sda_m = 1'b1; wait_c(H); scl_m = 1'b1; wait_c(H / 2);
    ack = !sda_bus; wait_c(H / 2); scl_m = 1'b0; wait_c(2);
  endtask

  task automatic get_byte(input bit ack_it, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wait_c(H); scl_m = 1'b1; wait_c(H / 2); b[i] = sda_bus;
      wait_c(H / 2); scl_m = 1'b0; wait_c(2);
    end
    sda_m = !ack_it; wait_c(H); scl_m = 1'b1; wait_c(H); scl_m = 1'b0; wait_c(2);
    sda_m = 1'b1;
  endtask

  task automatic wait_idle;
    for (int i = 0; i < 5000 && nv_busy; i++) wait_c(1);
  endtask

  task automatic cmd_frame(input logic [7:0] code);
    bit a;
    bus_start; put_byte(8'hD4, a); put_byte(code, a); bus_stop;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    bit a;
    logic [7:0] b;
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; shutdown = 1'b0;
    for (int i = 0; i < NREG; i++) rf[i] = 8'h80 + 8'(i);
    for (int i = 0; i < NREG; i++) saved[i] = 8'h00;
    wait_c(5);
    check(!sda_pull && !nv_busy && !crc_err && !reg_we, "R12 reset state",
          {sda_pull, nv_busy, crc_err, reg_we}, 0);
    rst_n = 1'b1; wait_c(5);

    // R1/R2: addressed write with pointer then three data bytes
    bus_start; put_byte(8'hD4, a);
    check(a, "R1 own address ack", a, 1);
    put_byte(8'h02, a);
    exp_wr.push_back({8'h02, 8'h11}); exp_wr.push_back({8'h03, 8'h22});
    exp_wr.push_back({8'h04, 8'h33});
    put_byte(8'h11, a); put_byte(8'h22, a); put_byte(8'h33, a); bus_stop;
    check(rf[2] == 8'h11 && rf[3] == 8'h22 && rf[4] == 8'h33, "R2 consecutive regs",
          {rf[2], rf[3], rf[4]}, 24'h112233);

    // R1: foreign address
    bus_start; put_byte(8'hA0, a);
    check(!a, "R1 foreign address nack", a, 0);
    put_byte(8'h55, a); bus_stop;
    check(exp_wr.size() == 0, "R1 no write on foreign frame", exp_wr.size(), 0);

    // R3/R4: set pointer, repeated START, read three bytes
    bus_start; put_byte(8'hD4, a); put_byte(8'h02, a);
    bus_start; put_byte(8'hD5, a);
    check(a, "R4 read address after repeated start", a, 1);
    get_byte(1'b1, b); check(b == 8'h11, "R3 read byte 0", b, 8'h11);
    get_byte(1'b1, b); check(b == 8'h22, "R3 read byte 1", b, 8'h22);
    get_byte(1'b0, b); check(b == 8'h33, "R3 read byte 2", b, 8'h33);
    bus_stop;
    bus_start; put_byte(8'hD5, a); get_byte(1'b0, b); bus_stop;
    check(b == 8'h85, "R3 pointer advanced on read", b, 8'h85);

    // R5: identification register
    bus_start; put_byte(8'hD4, a); put_byte(8'hFF, a);
    bus_start; put_byte(8'hD5, a); get_byte(1'b0, b); bus_stop;
    check(b == 8'h10, "R5 id value", b, 8'h10);
    bus_start; put_byte(8'hD4, a); put_byte(8'hFF, a); put_byte(8'h77, a); bus_stop;
    bus_start; put_byte(8'hD4, a); put_byte(8'hFF, a);
    bus_start; put_byte(8'hD5, a); get_byte(1'b0, b); bus_stop;
    check(b == 8'h10, "R5 id unchanged after write", b, 8'h10);

    // R6/R8: save
    for (int i = 0; i < NREG; i++) saved[i] = rf[i];
    cmd_frame(8'hC0);
    check(nv_busy, "R6 save launched", nv_busy, 1);
    // R7: address withheld while busy
    bus_start; put_byte(8'hD4, a);
    check(!a, "R7 nack while busy", a, 0);
    bus_stop;
    wait_idle;
    check(!nv_busy && !crc_err, "R8 save completed", {nv_busy, crc_err}, 0);

    // disturb registers, then restore
    bus_start; put_byte(8'hD4, a); put_byte(8'h00, a);
    for (int i = 0; i < 4; i++) begin
      exp_wr.push_back({8'(i), 8'hA0 + 8'(i)});
      put_byte(8'hA0 + 8'(i), a);
    end
    bus_stop;
    check(rf[0] == 8'hA0, "R2 disturb write", rf[0], 8'hA0);
    cmd_frame(8'hC1);
    check(nv_busy, "R6 restore launched", nv_busy, 1);
    wait_idle;
    for (int i = 0; i < NREG; i++)
      check(rf[i] == saved[i], "R8 restored contents", rf[i], saved[i]);

    // R6: three-byte frame starts nothing
    bus_start; put_byte(8'hD4, a); put_byte(8'hC0, a);
    exp_wr.push_back({8'hC0, 8'h01});
    put_byte(8'h01, a); bus_stop;
    check(!nv_busy, "R6 longer frame no launch", nv_busy, 0);

    // R9: refused under shutdown (launch and guard in the same cycle)
    shutdown = 1'b1;
    cmd_frame(8'hC0);
    wait_c(3);
    check(!nv_busy, "R9 refused in shutdown", nv_busy, 0);
    shutdown = 1'b0; wait_c(2);

    // R10: interrupted save, then clean save
    cmd_frame(8'hC0);
    wait_c(100);
    check(nv_busy, "R10 transfer running", nv_busy, 1);
    shutdown = 1'b1; wait_c(3);
    check(!nv_busy && crc_err, "R10 abort sets flag", {nv_busy, crc_err}, 2'b01);
    shutdown = 1'b0; wait_c(2);
    cmd_frame(8'hC0);
    check(crc_err, "R10 flag held at start", crc_err, 1);
    wait_idle;
    check(!crc_err, "R10 flag cleared", crc_err, 0);

    // R11: STOP mid-byte after pointer
    bus_start; put_byte(8'hD4, a); put_byte(8'h06, a); put_bits(8'hEE, 4); bus_stop;
    check(rf[6] == saved[6], "R11 no write on mid-byte stop", rf[6], saved[6]);
    // R11: STOP mid-byte after command byte
    bus_start; put_byte(8'hD4, a); put_byte(8'hC0, a); put_bits(8'h00, 3); bus_stop;
    wait_c(3);
    check(!nv_busy, "R11 no launch on mid-byte stop", nv_busy, 0);
    // R11: START mid-byte then read back pointer target
    bus_start; put_byte(8'hD4, a); put_byte(8'h08, a); put_bits(8'h99, 5);
    bus_start; put_byte(8'hD5, a); get_byte(1'b0, b); bus_stop;
    check(b == saved[8], "R11 mid-byte start keeps reg and pointer", b, saved[8]);

    check(exp_wr.size() == 0, "R2 all expected writes seen", exp_wr.size(), 0);
    summary();
  end
endmodule